// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is an SPI master that software drives through three 16-bit registers on a simple register bus: a data register, a control register and a status register. A write to the data register, while the block is enabled and idle, opens the chip select and shifts out either one byte or, in wide mode, two bytes back to back with the high byte first. The bits that come back on the serial input are gathered into the same data register. The transmit buffer is therefore replaced by the received word when the transfer completes.

The control register sets the serial clock rate through a 7-bit divider. It also sets the clock idle level, the sampling edge, the transfer width, the module enable and two interrupt enables. The status register reports an active transfer and a captured word that has not yet been read. A read of the data register hands software the received word and clears the unread flag. The single interrupt line is qualified by the module enable and by two enables, one for each source. The register bus uses halfword-aligned addresses with two byte-lane enables. Read data appears on the cycle after the read strobe.

Top module: `spi_regif`

## Requirements
- R1: After reset the data, control and status registers read 0x0000, irq is 0, spi_cs_n is 1 and spi_sck is 0.
- R2: The data register is at offset 0x0, control at 0x2 and status at 0x4 within a 12-bit address window. bus_be[0] writes bits 7:0 and bus_be[1] writes bits 15:8. bus_rdata holds the addressed register on the cycle after bus_rd. A read with bus_addr[0]=1, or of any other offset, returns 0x0000.
- R3: Control fields: bit 0 enable, bit 2 wide (16-bit) mode, bit 5 receive-full interrupt enable, bit 6 transfer-done interrupt enable, bit 7 clock phase, bit 8 clock idle level, bits 15:9 divider. All 16 bits read back as written.
- R4: In 8-bit mode, a data write shifts out bits 7:0 MSB first. The captured byte lands in bits 7:0 of the data register, with bits 15:8 zero.
- R5: In wide mode, bits 15:8 are shifted out first and bits 7:0 second, each MSB first. The received bits are assembled in the same order into bits 15:0.
- R6: A data write with at least one lane enabled starts a transfer only when the enable bit is 1 and the block is not busy. Status bit 0 (busy) is 1 from the cycle after the accepted write until the end of the hold period. A data write while busy or disabled changes neither the data register nor the status, and does not open the chip select.
- R7: The SCK half-period is (divider+1) clocks, and SCK rests at the idle-level bit when no transfer is running. spi_cs_n is low for the whole transfer, with exactly one half-period before the first SCK edge and one after the last.
- R8: With clock phase 0, spi_miso is sampled on the first edge of each bit and spi_mosi changes on the second. With clock phase 1 the two edges swap roles. Each transfer has 8 or 16 sampling edges.
- R9: The end of a transfer sets status bit 1 (receive full) and clears busy. A read of the data register returns the captured word and clears receive full. An accepted data write also clears it.
- R10: The status register is read-only, and writes to offset 0x4 leave it unchanged.
- R11: irq is 1 only while the enable bit is 1 and either busy is 0 with the transfer-done enable set, or receive full is 1 with the receive-full enable set. irq follows the register state one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address within the register window |
| bus_be | input | 2 | Byte-lane enables (bit 0 low byte, bit 1 high byte) |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_rd | input | 1 | Read strobe, one clock per access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data, valid the cycle after bus_rd |
| irq | output | 1 | Registered interrupt request |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out, MSB first |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The bench builds the block with its default 12-bit address window and the full 7-bit divider. Divider values 0 and 127 therefore both come within reach, and the bench measures the longest and the shortest SCK half-periods against the (divider+1) rule. Its slave returns the inverse of spi_mosi. Because of this, a swapped byte order or a wrong sampling edge shows up as a mismatch both in the captured word and in the recorded serial stream. Random transfers vary the width, phase, idle level, divider and interrupt enables from a fixed seed. Directed cases cover busy writes, disabled writes, status writes and the interrupt gating.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;

  localparam int BYTE_W  = 8;
  localparam int LANES   = 2;
  localparam int WORD_W  = BYTE_W * LANES;
  localparam int DIV_W   = 7;
  localparam int EDGE_W  = $clog2(2 * WORD_W + 1);

  // control register field positions
  localparam int CTL_EN      = 0;
  localparam int CTL_WIDE    = 2;
  localparam int CTL_RXIE    = 5;
  localparam int CTL_DNIE    = 6;
  localparam int CTL_CPHA    = 7;
  localparam int CTL_CPOL    = 8;
  localparam int CTL_DIV_LSB = 9;

  // status register bit positions
  localparam int ST_BUSY = 0;
  localparam int ST_RXF  = 1;

  // halfword register index (byte offset / 2)
  localparam int IDX_DATA = 0;
  localparam int IDX_CTRL = 1;
  localparam int IDX_STAT = 2;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_SHIFT = 2'd1,
    ENG_HOLD  = 2'd2
  } eng_state_e;

  function automatic logic [WORD_W-1:0] merge_lanes(
    input logic [WORD_W-1:0] old_v,
    input logic [WORD_W-1:0] new_v,
    input logic [LANES-1:0]  be
  );
    logic [WORD_W-1:0] r;
    r = old_v;
    for (int i = 0; i < LANES; i++) begin
      if (be[i]) r[i*BYTE_W +: BYTE_W] = new_v[i*BYTE_W +: BYTE_W];
    end
    return r;
  endfunction

endpackage

// File: rtl/spi_regif_engine.sv
module spi_regif_engine
  import spi_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              wide,
  input  logic              cpha,
  input  logic              cpol_idle,
  input  logic [DIV_W-1:0]  div,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rx_word,
  output logic              sck,
  output logic              mosi,
  output logic              cs_n
);

  eng_state_e        state;
  logic [DIV_W-1:0]  div_cnt;
  logic [DIV_W-1:0]  div_l;
  logic [EDGE_W-1:0] edges;
  logic              wide_l;
  logic              cpha_l;
  logic [WORD_W-1:0] tx_sr;
  logic [WORD_W-1:0] rx_sr;

  logic              tick;
  logic              sample_now;
  logic [EDGE_W-1:0] last_edge;

  assign tick       = (div_cnt == div_l);
  // an even count of finished edges means the next edge leads its bit
  assign sample_now = (~edges[0]) ^ cpha_l;
  assign last_edge  = wide_l ? EDGE_W'(2 * WORD_W) : EDGE_W'(2 * BYTE_W);

  assign busy    = (state != ENG_IDLE);
  assign done    = (state == ENG_HOLD) && tick;
  assign mosi    = tx_sr[WORD_W-1];
  assign rx_word = wide_l ? rx_sr : {{(WORD_W-BYTE_W){1'b0}}, rx_sr[BYTE_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ENG_IDLE;
      div_cnt <= '0;
      div_l   <= '0;
      edges   <= '0;
      wide_l  <= 1'b0;
      cpha_l  <= 1'b0;
      tx_sr   <= '0;
      rx_sr   <= '0;
      sck     <= 1'b0;
      cs_n    <= 1'b1;
    end else begin
      case (state)
        ENG_IDLE: begin
          sck  <= cpol_idle;
          cs_n <= 1'b1;
          if (start) begin
            state   <= ENG_SHIFT;
            cs_n    <= 1'b0;
            div_cnt <= '0;
            edges   <= '0;
            div_l   <= div;
            wide_l  <= wide;
            cpha_l  <= cpha;
            rx_sr   <= '0;
            tx_sr   <= wide ? tx_word : {tx_word[BYTE_W-1:0], {(WORD_W-BYTE_W){1'b0}}};
          end
        end
        ENG_SHIFT: begin
          if (tick) begin
            div_cnt <= '0;
            sck     <= ~sck;
            edges   <= edges + EDGE_W'(1);
            if (sample_now) begin
              rx_sr <= {rx_sr[WORD_W-2:0], miso};
            end else if (!(cpha_l && (edges == '0))) begin
              tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
            end
            if ((edges + EDGE_W'(1)) == last_edge) state <= ENG_HOLD;
          end else begin
            div_cnt <= div_cnt + DIV_W'(1);
          end
        end
        ENG_HOLD: begin
          if (tick) begin
            state   <= ENG_IDLE;
            cs_n    <= 1'b1;
            div_cnt <= '0;
            tx_sr   <= '0;
          end else begin
            div_cnt <= div_cnt + DIV_W'(1);
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  AST_SCK_REST_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy)) |-> (sck == $past(cpol_idle)))
    else $error("sck left its idle level outside a transfer"); // R7

  AST_CS_HELD_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> !cs_n)
    else $error("chip select released inside a transfer"); // R7

  AST_EDGE_BUDGET: assert property (@(posedge clk) disable iff (rst)
    busy |-> (edges <= last_edge))
    else $error("more sck edges than the transfer width allows"); // R8

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |=> (!busy && cs_n))
    else $error("busy survived the end of a transfer"); // R6

endmodule

// File: rtl/spi_regif_regs.sv
module spi_regif_regs
  import spi_regif_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [LANES-1:0]  bus_be,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              eng_busy,
  input  logic              eng_done,
  input  logic [WORD_W-1:0] eng_rx,
  output logic              start,
  output logic [WORD_W-1:0] tx_word,
  output logic [WORD_W-1:0] ctrl_q,
  output logic              irq
);

  localparam int IDX_W = ADDR_W - 1;

  logic [WORD_W-1:0] data_q;
  logic              rxf_q;
  logic [IDX_W-1:0]  idx;
  logic              aligned;
  logic              hit_data, hit_ctrl, hit_stat;
  logic [WORD_W-1:0] stat_v;

  assign idx      = bus_addr[ADDR_W-1:1];
  assign aligned  = ~bus_addr[0];
  assign hit_data = aligned && (idx == IDX_W'(IDX_DATA));
  assign hit_ctrl = aligned && (idx == IDX_W'(IDX_CTRL));
  assign hit_stat = aligned && (idx == IDX_W'(IDX_STAT));

  assign stat_v = {{(WORD_W-2){1'b0}}, rxf_q, eng_busy};

  assign tx_word = merge_lanes(data_q, bus_wdata, bus_be);
  assign start   = bus_wr && hit_data && (|bus_be) && ctrl_q[CTL_EN] && !eng_busy;

  // control register
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (bus_wr && hit_ctrl) begin
      ctrl_q <= merge_lanes(ctrl_q, bus_wdata, bus_be);
    end
  end

  // shared transmit / receive word
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
    end else if (eng_done) begin
      data_q <= eng_rx;
    end else if (start) begin
      data_q <= tx_word;
    end
  end

  // receive-full flag
  always_ff @(posedge clk) begin
    if (rst) begin
      rxf_q <= 1'b0;
    end else if (eng_done) begin
      rxf_q <= 1'b1;
    end else if (start || (bus_rd && hit_data)) begin
      rxf_q <= 1'b0;
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (hit_data)      bus_rdata <= data_q;
      else if (hit_ctrl) bus_rdata <= ctrl_q;
      else if (hit_stat) bus_rdata <= stat_v;
      else               bus_rdata <= '0;
    end
  end

  // interrupt request
  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else begin
      irq <= ctrl_q[CTL_EN] &&
             ((!eng_busy && ctrl_q[CTL_DNIE]) || (rxf_q && ctrl_q[CTL_RXIE]));
    end
  end

  AST_DONE_SETS_RXF: assert property (@(posedge clk) disable iff (rst)
    eng_done |=> rxf_q)
    else $error("completion did not raise receive full"); // R9

  AST_READ_CLEARS_RXF: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && hit_data && !eng_done) |=> !rxf_q)
    else $error("data read left receive full set"); // R9

  AST_BUSY_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
    (eng_busy && $past(eng_busy)) |-> $stable(data_q))
    else $error("data register moved during a transfer"); // R6

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ctrl_q[CTL_EN]))
    else $error("interrupt raised while disabled"); // R11

endmodule

// File: rtl/spi_regif.sv
module spi_regif
  import spi_regif_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_be,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              irq,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);

  logic              start;
  logic [WORD_W-1:0] tx_word;
  logic [WORD_W-1:0] ctrl_q;
  logic              eng_busy;
  logic              eng_done;
  logic [WORD_W-1:0] eng_rx;

  spi_regif_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .eng_busy  (eng_busy),
    .eng_done  (eng_done),
    .eng_rx    (eng_rx),
    .start     (start),
    .tx_word   (tx_word),
    .ctrl_q    (ctrl_q),
    .irq       (irq)
  );

  spi_regif_engine u_engine (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .tx_word   (tx_word),
    .wide      (ctrl_q[CTL_WIDE]),
    .cpha      (ctrl_q[CTL_CPHA]),
    .cpol_idle (ctrl_q[CTL_CPOL]),
    .div       (ctrl_q[CTL_DIV_LSB +: DIV_W]),
    .miso      (spi_miso),
    .busy      (eng_busy),
    .done      (eng_done),
    .rx_word   (eng_rx),
    .sck       (spi_sck),
    .mosi      (spi_mosi),
    .cs_n      (spi_cs_n)
  );

endmodule

// File: tb/tb_spi_regif.sv
`timescale 1ns/1ps
module tb_spi_regif;

  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [1:0]    bus_be = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [15:0]   bus_wdata = '0;
  logic [15:0]   bus_rdata;
  logic          irq, spi_sck, spi_mosi, spi_miso, spi_cs_n;

  always #2 clk = ~clk;

  // slave model: returns the inverse of what it receives
  assign spi_miso = ~spi_mosi;

  spi_regif #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // serial monitor
  bit          cur_cpol, cur_cpha;
  logic [15:0] mon_bits;
  int          mon_cnt, edge_seen, cs_falls;
  longint      first_t, last_t, cs_fall_t, cs_rise_t;

  always @(posedge spi_sck or negedge spi_sck) begin
    if (spi_cs_n === 1'b0) begin
      if (edge_seen == 0) first_t = $time;
      last_t = $time;
      edge_seen++;
      if ((spi_sck != cur_cpol) ^ cur_cpha) begin
        mon_bits = {mon_bits[14:0], spi_mosi};
        mon_cnt++;
      end
    end
  end
  always @(negedge spi_cs_n) begin cs_falls++; cs_fall_t = $time; end
  always @(posedge spi_cs_n) cs_rise_t = $time;

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
    end
  endtask

  task automatic wr16(input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd16(input logic [AW-1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [15:0] mk_ctrl(bit en, bit wide, bit rie, bit die,
                                          bit cpha, bit cpol, logic [6:0] dv);
    return {dv, cpol, cpha, die, rie, 2'b00, wide, 1'b0, en};
  endfunction

  function automatic logic [15:0] exp_rx(logic [15:0] tx, bit wide);
    return wide ? ~tx : {8'h00, ~tx[7:0]};
  endfunction

  task automatic wait_rxf(output logic [15:0] st);
    st = '0;
    for (int n = 0; n < 20000 && !st[1]; n++) rd16(12'h004, st);
  endtask

  task automatic xfer(input bit wide, input bit cpha, input bit cpol,
                      input logic [6:0] dv, input bit rie, input bit die,
                      input logic [15:0] tx);
    logic [15:0] st, d;
    longint h;
    int nb;
    string tg;
    tg = wide ? (cpha ? "R5/R8" : "R5") : (cpha ? "R4/R8" : "R4");
    h  = (longint'(dv) + 1) * 4;
    nb = wide ? 16 : 8;
    wr16(12'h002, mk_ctrl(1'b1, wide, rie, die, cpha, cpol, dv), 2'b11);
    cur_cpol = cpol; cur_cpha = cpha;
    repeat (2) @(negedge clk);
    chk("R7", "sck idle level", {31'd0, spi_sck}, {31'd0, cpol});
    mon_cnt = 0; edge_seen = 0; mon_bits = '0;
    wr16(12'h000, tx, 2'b11);
    wait_rxf(st);
    chk("R9", "status after completion", {16'd0, st}, 32'h2);
    chk("R8", "sampling edges", mon_cnt, nb);
    chk("R7", "sck edges", edge_seen, 2 * nb);
    chk(tg, "serial stream", {16'd0, wide ? mon_bits : {8'h00, mon_bits[7:0]}},
        {16'd0, wide ? tx : {8'h00, tx[7:0]}});
    chk("R7", "edge span", 32'(last_t - first_t), 32'((2 * nb - 1) * h));
    chk("R7", "cs setup", 32'(first_t - cs_fall_t), 32'(h));
    chk("R7", "cs hold", 32'(cs_rise_t - last_t), 32'(h));
    repeat (2) @(negedge clk);
    chk("R11", "irq with word pending", {31'd0, irq}, {31'd0, rie | die});
    rd16(12'h000, d);
    chk(tg, "received word", {16'd0, d}, {16'd0, exp_rx(tx, wide)});
    rd16(12'h004, st);
    chk("R9", "status after data read", {16'd0, st}, 32'h0);
    repeat (2) @(negedge clk);
    chk("R11", "irq after data read", {31'd0, irq}, {31'd0, die});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] d, st;
    int falls0;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    rd16(12'h000, d); chk("R1", "data after reset", {16'd0, d}, 32'h0);
    rd16(12'h002, d); chk("R1", "ctrl after reset", {16'd0, d}, 32'h0);
    rd16(12'h004, d); chk("R1", "status after reset", {16'd0, d}, 32'h0);
    chk("R1", "irq after reset", {31'd0, irq}, 32'h0);
    chk("R1", "cs_n after reset", {31'd0, spi_cs_n}, 32'h1);
    chk("R1", "sck after reset", {31'd0, spi_sck}, 32'h0);

    // R2 / R3: lane writes and readback
    wr16(12'h002, 16'h00A4, 2'b01);
    wr16(12'h002, 16'h5A00, 2'b10);
    rd16(12'h002, d); chk("R3", "ctrl readback", {16'd0, d}, 32'h5AA4);
    wr16(12'h002, 16'h01FF, 2'b10);
    rd16(12'h002, d); chk("R2", "high lane only", {16'd0, d}, 32'h01A4);
    repeat (2) @(negedge clk);
    chk("R7", "sck follows idle bit", {31'd0, spi_sck}, 32'h1);
    rd16(12'h006, d); chk("R2", "unmapped offset", {16'd0, d}, 32'h0);
    rd16(12'h003, d); chk("R2", "odd address", {16'd0, d}, 32'h0);
    rd16(12'h802, d); chk("R2", "far offset", {16'd0, d}, 32'h0);

    // R6: data write while disabled is ignored
    wr16(12'h002, 16'h0000, 2'b11);
    falls0 = cs_falls;
    wr16(12'h000, 16'h1234, 2'b11);
    repeat (4) @(negedge clk);
    chk("R6", "no chip select when disabled", cs_falls, falls0);
    rd16(12'h004, st); chk("R6", "status when disabled", {16'd0, st}, 32'h0);
    rd16(12'h000, d); chk("R6", "data when disabled", {16'd0, d}, 32'h0);

    // R11: interrupt gating while idle
    wr16(12'h002, mk_ctrl(1'b0, 0, 0, 1'b1, 0, 0, 7'd0), 2'b11);
    repeat (2) @(negedge clk);
    chk("R11", "done enable without module enable", {31'd0, irq}, 32'h0);
    wr16(12'h002, mk_ctrl(1'b1, 0, 1'b1, 1'b0, 0, 0, 7'd0), 2'b11);
    repeat (2) @(negedge clk);
    chk("R11", "rx enable with nothing received", {31'd0, irq}, 32'h0);
    wr16(12'h002, mk_ctrl(1'b1, 0, 0, 1'b1, 0, 0, 7'd0), 2'b11);
    repeat (2) @(negedge clk);
    chk("R11", "done enable while idle", {31'd0, irq}, 32'h1);

    // directed transfers
    xfer(1'b1, 1'b0, 1'b0, 7'd0,   1'b1, 1'b0, 16'hA53C);
    xfer(1'b1, 1'b1, 1'b1, 7'd3,   1'b0, 1'b1, 16'h1E87);
    xfer(1'b0, 1'b0, 1'b1, 7'd127, 1'b1, 1'b0, 16'hBEEF);
    xfer(1'b1, 1'b1, 1'b0, 7'd127, 1'b0, 1'b0, 16'h8001);
    xfer(1'b0, 1'b1, 1'b1, 7'd0,   1'b1, 1'b1, 16'h0096);

    // R6: writes while busy are ignored
    wr16(12'h002, mk_ctrl(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 7'd20), 2'b11);
    cur_cpol = 0; cur_cpha = 0;
    repeat (2) @(negedge clk);
    mon_cnt = 0; edge_seen = 0; mon_bits = '0;
    falls0 = cs_falls;
    wr16(12'h000, 16'h4321, 2'b11);
    rd16(12'h004, st); chk("R6", "busy during transfer", {16'd0, st}, 32'h1);
    chk("R11", "done irq held off while busy", {31'd0, irq}, 32'h0);
    wr16(12'h000, 16'hFFFF, 2'b11);
    wait_rxf(st);
    chk("R6", "single chip select", cs_falls, falls0 + 1);
    chk("R6", "single byte pair", mon_cnt, 16);
    chk("R6", "first stream kept", {16'd0, mon_bits}, 32'h4321);

    // R11: receive-full source gated by enable
    wr16(12'h002, mk_ctrl(1'b0, 1'b1, 1'b1, 1'b0, 0, 0, 7'd20), 2'b11);
    repeat (2) @(negedge clk);
    chk("R11", "rx full without module enable", {31'd0, irq}, 32'h0);
    wr16(12'h002, mk_ctrl(1'b1, 1'b1, 1'b1, 1'b0, 0, 0, 7'd20), 2'b11);
    repeat (2) @(negedge clk);
    chk("R11", "rx full with enable", {31'd0, irq}, 32'h1);

    // R10: status is read-only
    wr16(12'h004, 16'h0000, 2'b11);
    rd16(12'h004, st); chk("R10", "status write of zero", {16'd0, st}, 32'h2);
    rd16(12'h000, d);  chk("R6", "busy write ignored", {16'd0, d}, {16'd0, ~16'h4321});
    wr16(12'h004, 16'hFFFF, 2'b11);
    rd16(12'h004, st); chk("R10", "status write of ones", {16'd0, st}, 32'h0);

    // random transfers
    for (int i = 0; i < 20; i++) begin
      logic [31:0] r;
      r = $urandom;
      xfer(r[0], r[1], r[2], 7'(r[5:3] % 6), r[6], r[7], r[31:16]);
    end

    summary();
    $finish;
  end

endmodule